// File: doc/BRIEF.md
# Parallel Contention Arbitration Competitor

This block is one module's share of a distributed arbitration on a shared wired-OR bus. A local port loads an arbitration number and its parity bit into a holding register. When the module is told to compete, it drives its number onto the bus. It takes back each lower-order bit as soon as a higher-order bus bit shows that some other module holds a larger number. Every competitor runs the same rule at the same time, so the resolved bus settles to the largest competing number. The block does not resolve the bus itself. It presents its bit drives on an output vector and reads back the resolved value, in active-high logical form. The OR of all modules' drives is formed outside the block.

The block has a single active-low win output, and its meaning depends on whether the module is competing. While competing, the output reports that this module's number is the one standing on the bus. While not competing, it reports that the loaded number is greater than or equal to the bus number. Two status outputs watch the resolved bus at all times. One flags whether the nine bus bits carry odd parity. The other flags that all eight number bits are set. The arbitration and powerfail message numbers are detected through that all-set flag. A receive enable hands the resolved bus value back to the local port, which is modelled as a value plus an output enable.

Top module: `arb_contender`

## Requirements
- R1: A rising clock edge with `load_n` low captures `num_in` and `par_in` into the holding register. With `load_n` high the register keeps its value. Reset clears it to zero.
- R2: With `compete_n` high, `drive_out` and `drive_par_out` are all zero.
- R3: With `compete_n` low, `drive_out[n]` is 1 exactly when the held bit n is 1 and, for every higher bit k, either the held bit k is 1 or `bus_in[k]` is 0.
- R4: When several instances compete and their drives are ORed back to `bus_in` until nothing changes, the settled bus equals the largest competing held number. With no competitor the settled bus is zero.
- R5: With `compete_n` low, `win_n` is 0 exactly when `bus_in` equals the held number.
- R6: With `compete_n` high, `win_n` is 0 exactly when the held number is greater than or equal to `bus_in`, as unsigned values.
- R7: With `compete_n` low, `drive_par_out` equals the held parity bit when `bus_in` equals the held number. Otherwise it is 1 exactly when `bus_in` has an even number of ones.
- R8: `par_ok` is 1 exactly when `bus_in` together with `bus_par_in` holds an odd number of ones.
- R9: `all_set` is 1 exactly when every bit of `bus_in` is 1.
- R10: `num_oe` is 1 exactly when `rx_en_n` is 0, and `num_out` presents `bus_in`.
- R11: Two competitors that hold the same highest number both see `win_n` at 0 once the bus settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| num_in | input | NUM_W | Local arbitration number to load |
| par_in | input | 1 | Local parity bit to load |
| load_n | input | 1 | Load enable, active low |
| compete_n | input | 1 | Compete request, active low |
| rx_en_n | input | 1 | Receive enable, active low |
| bus_in | input | NUM_W | Resolved bus number bits, active high |
| bus_par_in | input | 1 | Resolved bus parity bit, active high |
| drive_out | output | NUM_W | This module's bit drives onto the bus |
| drive_par_out | output | 1 | This module's parity drive onto the bus |
| num_out | output | NUM_W | Resolved bus value toward the local port |
| num_oe | output | 1 | Local port output enable |
| win_n | output | 1 | Win or greater-or-equal result, active low |
| par_ok | output | 1 | Odd parity seen on the resolved bus |
| all_set | output | 1 | All number bits set on the resolved bus |

## Verification
A winning competitor's parity drive and the parity status can meet in the same settled bus state. The winner drives its held parity bit while every loser drives the parity recomputed from the bus. A deliberately wrong held parity must therefore show up, or be masked by the OR, depending on which modules compete. Contests run among three ORed instances with pseudo-random numbers, competing subsets and forced ties. The bench predicts the largest number and the ORed parity arithmetically and compares the bus, every win output and the parity flag. The bit-drive rule, the compare path and the bus status outputs are also swept over every held-number and bus combination.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      KEEP_RIPPLE   = 1'b0,
      KEEP_PARALLEL = 1'b1
   } keep_style_e;

   localparam int unsigned ARB_NUM_W_DEF = 8;
endpackage

// File: rtl/arb_num_store.sv
module arb_num_store #(
   parameter int unsigned NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic [NUM_W-1:0] num_d,
   input  logic             par_d,
   output logic [NUM_W-1:0] num_q,
   output logic             par_q
);
   generate
      if (NUM_W < 2) begin : g_bad_width
         $error("arb_num_store: NUM_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q <= '0;
         par_q <= 1'b0;
      end else if (!load_n) begin
         num_q <= num_d;
         par_q <= par_d;
      end
   end
endmodule

// File: rtl/arb_contend_net.sv
module arb_contend_net
   import arb_pkg::*;
#(
   parameter int unsigned NUM_W = 8,
   parameter keep_style_e STYLE = KEEP_PARALLEL
) (
   input  logic             active,
   input  logic [NUM_W-1:0] own,
   input  logic [NUM_W-1:0] bus,
   output logic [NUM_W-1:0] drive
);
   localparam int unsigned MSB = NUM_W - 1;

   // A higher bit lets lower bits stay driven when this module also
   // holds a 1 there, or when nobody has pulled the bus bit up.
   logic [NUM_W-1:0] hold_ok;
   logic [NUM_W-1:0] keep;

   assign hold_ok = own | ~bus;

   generate
      if (NUM_W < 2) begin : g_bad_width
         $error("arb_contend_net: NUM_W must be at least 2");
      end

      if (STYLE == KEEP_PARALLEL) begin : g_parallel
         assign keep[MSB] = 1'b1;
         for (genvar n = 0; n < MSB; n++) begin : g_bit
            assign keep[n] = &hold_ok[MSB:n+1];
         end
      end else begin : g_ripple
         assign keep[MSB] = 1'b1;
         for (genvar n = MSB; n > 0; n--) begin : g_bit
            assign keep[n-1] = keep[n] & hold_ok[n];
         end
      end
   endgenerate

   assign drive = active ? (own & keep) : '0;
endmodule

// File: rtl/arb_bus_status.sv
module arb_bus_status #(
   parameter int unsigned NUM_W = 8
) (
   input  logic [NUM_W-1:0] bus,
   input  logic             bus_par,
   output logic             par_ok,
   output logic             all_set
);
   generate
      if (NUM_W < 2) begin : g_bad_width
         $error("arb_bus_status: NUM_W must be at least 2");
      end
   endgenerate

   assign par_ok  = ^{bus, bus_par};
   assign all_set = &bus;
endmodule

// File: rtl/arb_contender.sv
module arb_contender
   import arb_pkg::*;
#(
   parameter int unsigned NUM_W = ARB_NUM_W_DEF,
   parameter keep_style_e STYLE = KEEP_PARALLEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_W-1:0] num_in,
   input  logic             par_in,
   input  logic             load_n,
   input  logic             compete_n,
   input  logic             rx_en_n,
   input  logic [NUM_W-1:0] bus_in,
   input  logic             bus_par_in,
   output logic [NUM_W-1:0] drive_out,
   output logic             drive_par_out,
   output logic [NUM_W-1:0] num_out,
   output logic             num_oe,
   output logic             win_n,
   output logic             par_ok,
   output logic             all_set
);
   localparam int unsigned MSB = NUM_W - 1;

   logic [NUM_W-1:0] own_q;
   logic             own_par_q;
   logic             competing;
   logic             bus_is_mine;
   logic             own_ge_bus;

   generate
      if (NUM_W < 2 || NUM_W > 32) begin : g_bad_width
         $error("arb_contender: NUM_W must lie in 2..32");
      end
   endgenerate

   arb_num_store #(.NUM_W(NUM_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .num_d  (num_in),
      .par_d  (par_in),
      .num_q  (own_q),
      .par_q  (own_par_q)
   );

   assign competing = ~compete_n;

   arb_contend_net #(.NUM_W(NUM_W), .STYLE(STYLE)) u_net (
      .active (competing),
      .own    (own_q),
      .bus    (bus_in),
      .drive  (drive_out)
   );

   arb_bus_status #(.NUM_W(NUM_W)) u_status (
      .bus     (bus_in),
      .bus_par (bus_par_in),
      .par_ok  (par_ok),
      .all_set (all_set)
   );

   assign bus_is_mine = (bus_in == own_q);
   assign own_ge_bus  = (own_q >= bus_in);

   // A winner sends its stored parity; everyone else follows the bus,
   // so all drivers agree once the number bits have settled.
   assign drive_par_out = competing & (bus_is_mine ? own_par_q : ~^bus_in);
   assign win_n         = competing ? ~bus_is_mine : ~own_ge_bus;

   assign num_out = bus_in;
   assign num_oe  = ~rx_en_n;

   // R1: a load strobe lands in the holding register one edge later
   a_r1_capture : assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (own_q == $past(num_in)) && (own_par_q == $past(par_in)));

   // R2: an idle module leaves the bus alone
   a_r2_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      compete_n |-> (drive_out == '0) && !drive_par_out);

   // R3: never drive a bit the stored number does not have
   a_r3_drive_subset : assert property (@(posedge clk) disable iff (!rst_n)
      (drive_out & ~own_q) == '0);

   // R3: the top bit is never withdrawn while competing
   a_r3_msb_follow : assert property (@(posedge clk) disable iff (!rst_n)
      (competing && own_q[MSB]) |-> drive_out[MSB]);

   // R5: a module whose number stands on the bus keeps driving all of it
   a_r5_winner_keeps : assert property (@(posedge clk) disable iff (!rst_n)
      (competing && !win_n) |-> (drive_out == own_q));

   // R9: the all-set flag agrees with the value handed to the local port
   a_r9_allset_rx : assert property (@(posedge clk) disable iff (!rst_n)
      all_set |-> (num_out == {NUM_W{1'b1}}));
endmodule

// File: tb/tb_arb_contender.sv
module tb_arb_contender;
   localparam int W  = 8;
   localparam int NI = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] num_in   [NI];
   logic         par_in   [NI];
   logic         load_n   [NI];
   logic         compete_n[NI];
   logic         rx_en_n  [NI];
   logic [W-1:0] bus_in;
   logic         bus_par_in;
   logic [W-1:0] drive_out[NI];
   logic         drive_par[NI];
   logic [W-1:0] num_out  [NI];
   logic         num_oe   [NI];
   logic         win_n    [NI];
   logic         par_ok   [NI];
   logic         all_set  [NI];

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   arb_contender #(.NUM_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .num_in(num_in[0]), .par_in(par_in[0]),
      .load_n(load_n[0]), .compete_n(compete_n[0]), .rx_en_n(rx_en_n[0]),
      .bus_in(bus_in), .bus_par_in(bus_par_in),
      .drive_out(drive_out[0]), .drive_par_out(drive_par[0]),
      .num_out(num_out[0]), .num_oe(num_oe[0]), .win_n(win_n[0]),
      .par_ok(par_ok[0]), .all_set(all_set[0]));

   arb_contender #(.NUM_W(W)) u_peer1 (
      .clk(clk), .rst_n(rst_n), .num_in(num_in[1]), .par_in(par_in[1]),
      .load_n(load_n[1]), .compete_n(compete_n[1]), .rx_en_n(rx_en_n[1]),
      .bus_in(bus_in), .bus_par_in(bus_par_in),
      .drive_out(drive_out[1]), .drive_par_out(drive_par[1]),
      .num_out(num_out[1]), .num_oe(num_oe[1]), .win_n(win_n[1]),
      .par_ok(par_ok[1]), .all_set(all_set[1]));

   arb_contender #(.NUM_W(W), .STYLE(arb_pkg::KEEP_RIPPLE)) u_peer2 (
      .clk(clk), .rst_n(rst_n), .num_in(num_in[2]), .par_in(par_in[2]),
      .load_n(load_n[2]), .compete_n(compete_n[2]), .rx_en_n(rx_en_n[2]),
      .bus_in(bus_in), .bus_par_in(bus_par_in),
      .drive_out(drive_out[2]), .drive_par_out(drive_par[2]),
      .num_out(num_out[2]), .num_oe(num_oe[2]), .win_n(win_n[2]),
      .par_ok(par_ok[2]), .all_set(all_set[2]));

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      return s * 32'd1103515245 + 32'd12345;
   endfunction

   // drive rule from R3, evaluated bit by bit
   function automatic logic [W-1:0] exp_drive(input logic [W-1:0] own,
                                              input logic [W-1:0] bus);
      logic [W-1:0] d;
      for (int n = 0; n < W; n++) begin
         bit keep = 1;
         for (int k = n + 1; k < W; k++)
            if (!own[k] && bus[k]) keep = 0;
         d[n] = own[n] && keep;
      end
      return d;
   endfunction

   task automatic load_all(input logic [W-1:0] v0, input logic p0,
                           input logic [W-1:0] v1, input logic p1,
                           input logic [W-1:0] v2, input logic p2);
      @(negedge clk);
      num_in[0] = v0; par_in[0] = p0;
      num_in[1] = v1; par_in[1] = p1;
      num_in[2] = v2; par_in[2] = p2;
      for (int i = 0; i < NI; i++) load_n[i] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NI; i++) load_n[i] = 1'b1;
   endtask

   // OR the drives back onto the bus until it stops moving
   task automatic settle();
      logic [W-1:0] b;
      logic         p;
      bus_in = '0; bus_par_in = 1'b0;
      for (int it = 0; it < 24; it++) begin
         #1;
         b = drive_out[0] | drive_out[1] | drive_out[2];
         p = drive_par[0] | drive_par[1] | drive_par[2];
         if (b == bus_in && p == bus_par_in) break;
         bus_in = b; bus_par_in = p;
      end
      #1;
   endtask

   initial begin
      #(1_500_000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NI; i++) begin
         num_in[i] = '0; par_in[i] = 1'b0; load_n[i] = 1'b1;
         compete_n[i] = 1'b1; rx_en_n[i] = 1'b1;
      end
      bus_in = '0; bus_par_in = 1'b0;
      #23 rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state: nobody competes, nothing is driven
      chk(drive_out[0] == '0, "R2 reset drive", drive_out[0], 0);
      chk(drive_par[0] == 1'b0, "R2 reset parity drive", drive_par[0], 0);
      chk(num_oe[0] == 1'b0, "R10 reset oe", num_oe[0], 0);

      // R1 reset clears the register: a lone competitor settles at zero
      compete_n[0] = 1'b0;
      settle();
      chk(bus_in == '0, "R1 reset value", bus_in, 0);
      chk(win_n[0] == 1'b0, "R5 lone zero wins", win_n[0], 0);
      compete_n[0] = 1'b1;

      // R1 load then hold
      load_all(8'hA5, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1);
      @(negedge clk);
      num_in[0] = 8'h3C; par_in[0] = 1'b0;
      @(posedge clk); @(negedge clk);
      compete_n[0] = 1'b0;
      settle();
      chk(bus_in == 8'hA5, "R1 held number", bus_in, 8'hA5);
      chk(drive_par[0] == 1'b1, "R1 held parity", drive_par[0], 1);
      compete_n[0] = 1'b1;
      #1;
      chk(drive_out[0] == '0, "R2 withdraw", drive_out[0], 0);

      // R6 R8 R9 R10 sweep of the bus against a fixed idle number
      for (int b = 0; b < 256; b++) begin
         for (int p = 0; p < 2; p++) begin
            bus_in = b[W-1:0]; bus_par_in = p[0];
            rx_en_n[0] = b[0] ^ p[0];
            #1;
            chk(win_n[0] == !(8'hA5 >= b[W-1:0]), "R6 ge compare", win_n[0], !(8'hA5 >= b));
            chk(par_ok[0] == ^{b[W-1:0], p[0]}, "R8 parity", par_ok[0], ^{b[W-1:0], p[0]});
            chk(all_set[0] == (b == 255), "R9 all set", all_set[0], b == 255);
            chk(num_oe[0] == !(b[0] ^ p[0]), "R10 oe", num_oe[0], !(b[0] ^ p[0]));
            chk(num_out[0] == b[W-1:0], "R10 value", num_out[0], b);
            chk(drive_out[0] == '0, "R2 idle sweep", drive_out[0], 0);
         end
      end
      rx_en_n[0] = 1'b1;

      // R3 R5 R7 exhaustive held number against bus value, dut alone
      for (int o = 0; o < 256; o++) begin
         load_all(o[W-1:0], o[0], 8'h00, 1'b1, 8'h00, 1'b1);
         compete_n[0] = 1'b0;
         for (int b = 0; b < 256; b++) begin
            logic [W-1:0] ed;
            logic         ep;
            bus_in = b[W-1:0]; bus_par_in = 1'b0;
            #1;
            ed = exp_drive(o[W-1:0], b[W-1:0]);
            ep = (o == b) ? o[0] : ~^b[W-1:0];
            chk(drive_out[0] == ed, "R3 bit drive", drive_out[0], ed);
            chk(drive_par[0] == ep, "R7 parity drive", drive_par[0], ep);
            chk(win_n[0] == (o != b), "R5 compete win", win_n[0], o != b);
         end
         compete_n[0] = 1'b1;
      end

      // R7 R8 wrong stored parity on a lone winner reaches the bus
      load_all(8'h81, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1);
      compete_n[0] = 1'b0;
      settle();
      chk(par_ok[0] == 1'b0, "R8 lone bad parity", par_ok[0], 0);
      compete_n[0] = 1'b1;

      // R4 R5 R6 R7 R11 contests among three instances
      for (int t = 0; t < 400; t++) begin
         logic [W-1:0] v [NI];
         logic         pv[NI];
         logic [2:0]   m;
         logic [W-1:0] mx;
         logic         ep;
         for (int i = 0; i < NI; i++) begin
            seed = nxt(seed);
            v[i] = seed[23:16];
            pv[i] = ~^v[i] ^ (seed[9:7] == 3'd0);
         end
         if (t % 4 == 1) v[1] = v[0];
         if (t % 16 == 3) v[2] = 8'hFF;
         seed = nxt(seed);
         m = seed[14:12];
         if (t % 8 == 0) m = 3'b011;
         load_all(v[0], pv[0], v[1], pv[1], v[2], pv[2]);
         mx = '0;
         for (int i = 0; i < NI; i++) begin
            compete_n[i] = !m[i];
            if (m[i] && v[i] > mx) mx = v[i];
         end
         settle();
         ep = 1'b0;
         for (int i = 0; i < NI; i++)
            if (m[i]) ep = ep | ((v[i] == mx) ? pv[i] : ~^mx);
         chk(bus_in == mx, "R4 settled maximum", bus_in, mx);
         chk(par_ok[0] == ^{mx, ep}, "R7 R8 contest parity", par_ok[0], ^{mx, ep});
         chk(all_set[1] == (mx == 8'hFF), "R9 contest all set", all_set[1], mx == 8'hFF);
         for (int i = 0; i < NI; i++) begin
            if (m[i])
               chk(win_n[i] == (v[i] != mx), "R5 R11 contest win", win_n[i], v[i] != mx);
            else
               chk(win_n[i] == !(v[i] >= mx), "R6 contest ge", win_n[i], !(v[i] >= mx));
         end
         for (int i = 0; i < NI; i++) compete_n[i] = 1'b1;
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule